// File: doc/BRIEF.md
# Quarter-Wave Sine Synthesizer Core

This core produces a continuous stream of signed sine samples for a downstream DAC. A tuning register holds the frequency control word. A phase accumulator adds that word to itself on every clock and wraps modulo 2^16. One full wrap of the accumulator is one period of the output. The output frequency is therefore the tuning word times the clock frequency divided by 2^16.

Only the upper phase bits address the amplitude table. The table holds the first quarter of a sine period and is computed when the design is elaborated. The two top phase bits select the quadrant. The second bit mirrors the table index, and the top bit negates the looked-up magnitude. Together these rebuild the full cycle from a quarter of the storage.

A new tuning word is captured on a load strobe. It changes the step size without disturbing the running phase, so frequency switches stay phase-continuous.

Top module: `dds_quarter_sine`

## Requirements
- R1: When `tune_load_i` is high at a rising clock edge, `tune_i` is captured and is used as the step from the next edge on. When the strobe is low, `tune_i` is ignored. A load never alters the accumulated phase.
- R2: On every rising edge the 16-bit phase becomes the previous phase plus the held tuning word, modulo 2^16. A tuning word of 0 freezes the output, and 0xFFFF steps the phase down by one per cycle.
- R3: For a tuning word T that divides 65536, the output repeats every 65536/T cycles. This is checked as the spacing between consecutive negative-to-nonnegative transitions of the sample.
- R4: The table index is phase bits [13:6]. Phase bits [5:0] only add resolution. With T=1, the sample changes at most once per 64 cycles.
- R5: In quadrant 0 (phase[15:14]=00), the index i=phase[13:6] is used directly and the sample is +M(i).
- R6: In quadrant 1 (phase[15:14]=01), the index is mirrored by bit inversion to 255-i and the sample is +M(255-i).
- R7: In quadrants 2 and 3 (phase[15]=1), the same forward and mirrored addressing is used, and the sample is -M(index).
- R8: The table has 256 entries of 15 bits each, with M(i) = round(32767 x sin((2i+1) x pi/1024)) to within 1 LSB. `sample_o` is 16-bit two's complement.
- R9: The sample reflects the phase register value from two clocks earlier. `sample_valid_o` rises on the second rising edge after reset is released and then stays high.
- R10: An asynchronous active-low reset clears the phase, the tuning word, the sample and the valid flag. After release, the output holds M(0) until a word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_i | input | 16 | Frequency control word to load |
| tune_load_i | input | 1 | Captures `tune_i` into the tuning register |
| sample_o | output | 16 | Signed sine sample |
| sample_valid_o | output | 1 | High once the pipeline holds a real sample |

## Verification
The bound checker checks these on every cycle:
- the sample's sign follows the phase MSB from two cycles earlier;
- the tuning register stays unchanged without a strobe;
- a frozen phase gives a frozen output;
- the valid flag never drops;
- reset clears the outputs.

Only the bench scenarios can show the following:
- the exact table magnitudes;
- the quadrant mirroring;
- the output period for each tuning word;
- the insensitivity to the low phase bits.

For these, the bench runs an independent phase and sine model next to the core, over several tuning words, mid-run loads and a wrap-down word.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

  localparam longint PI_Q30 = 64'sd3373259426;

  // round(full_scale * sin((2*idx+1) * pi / (4 * 2^depth_log2))) with integer Taylor series
  function automatic int quarter_sine_mag(input int idx, input int depth_log2, input int mag_w);
    longint x, term, acc, full;
    x    = (longint'(2 * idx + 1) * PI_Q30) >>> (depth_log2 + 2);
    acc  = x;
    term = x;
    for (int k = 1; k < 10; k++) begin
      term = -((((term * x) >>> 30) * x) >>> 30) / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    full = (longint'(1) <<< mag_w) - 1;
    return int'((acc * full + (longint'(1) <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] tune_i,
  input  logic               tune_load_i,
  output logic [PHASE_W-1:0] tune_o,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] tune_q, phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_q  <= '0;
      phase_q <= '0;
    end else begin
      if (tune_load_i) tune_q <= tune_i;
      phase_q <= phase_q + tune_q;  // modulo 2^PHASE_W by width
    end
  end

  assign tune_o  = tune_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/dds_fold.sv
`timescale 1ns/1ps
module dds_fold #(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               neg_o,
  output logic               valid_o
);

  localparam int IDX_HI = PHASE_W - 3;
  localparam int IDX_LO = PHASE_W - 2 - IDX_W;

  logic [IDX_W-1:0] raw_idx;
  logic             mirror;
  logic             unused_lo;

  assign raw_idx   = phase_i[IDX_HI:IDX_LO];
  assign mirror    = phase_i[PHASE_W-2];
  assign unused_lo = ^phase_i[IDX_LO-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      neg_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      idx_o   <= mirror ? ~raw_idx : raw_idx;
      neg_o   <= phase_i[PHASE_W-1];
      valid_o <= 1'b1;
    end
  end

endmodule

// File: rtl/dds_quarter_rom.sv
`timescale 1ns/1ps
module dds_quarter_rom #(
  parameter int IDX_W = 8,
  parameter int MAG_W = 15
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [MAG_W-1:0] mag_o
);

  localparam int DEPTH = 1 << IDX_W;

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign tbl[g] = MAG_W'(dds_pkg::quarter_sine_mag(g, IDX_W, MAG_W));
  end

  assign mag_o = tbl[idx_i];

endmodule

// File: rtl/dds_quarter_sine.sv
`timescale 1ns/1ps
module dds_quarter_sine #(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 8,
  parameter int MAG_W   = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] tune_i,
  input  logic               tune_load_i,
  output logic [MAG_W:0]     sample_o,
  output logic               sample_valid_o
);

  localparam int SAMPLE_W = MAG_W + 1;

  logic [PHASE_W-1:0]  tune_q, phase_q;
  logic [IDX_W-1:0]    idx_q;
  logic                neg_q, fold_vld;
  logic [MAG_W-1:0]    mag;
  logic [SAMPLE_W-1:0] mag_ext, sample_q;
  logic                valid_q;

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tune_i      (tune_i),
    .tune_load_i (tune_load_i),
    .tune_o      (tune_q),
    .phase_o     (phase_q)
  );

  dds_fold #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_fold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase_q),
    .idx_o   (idx_q),
    .neg_o   (neg_q),
    .valid_o (fold_vld)
  );

  dds_quarter_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
    .idx_i (idx_q),
    .mag_o (mag)
  );

  assign mag_ext = {1'b0, mag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      sample_q <= neg_q ? (~mag_ext + 1'b1) : mag_ext;
      valid_q  <= fold_vld;
    end
  end

  assign sample_o       = sample_q;
  assign sample_valid_o = valid_q;

endmodule

// File: rtl/dds_quarter_sine_chk.sv
`timescale 1ns/1ps
module dds_quarter_sine_chk #(
  parameter int PHASE_W  = 16,
  parameter int SAMPLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tune_load_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                sample_valid_o,
  input logic [PHASE_W-1:0]  phase_q,
  input logic [PHASE_W-1:0]  tune_q
);

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (sample_o == '0 && !sample_valid_o)); // R10

  AST_TUNE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tune_load_i |=> $stable(tune_q)); // R1

  AST_SIGN_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> (sample_o[SAMPLE_W-1] == $past(phase_q[PHASE_W-1], 2))); // R7

  AST_FROZEN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && $past(phase_q) == $past(phase_q, 2)) |=> $stable(sample_o)); // R2

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> sample_valid_o); // R9

  AST_NO_ZERO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> sample_o != '0); // R8

endmodule

bind dds_quarter_sine dds_quarter_sine_chk #(.PHASE_W(PHASE_W), .SAMPLE_W(MAG_W + 1)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tune_load_i    (tune_load_i),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o),
  .phase_q        (phase_q),
  .tune_q         (tune_q)
);

// File: tb/tb_dds_quarter_sine.sv
`timescale 1ns/1ps
module tb_dds_quarter_sine;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [15:0] tune_i = '0;
  logic        tune_load_i = 1'b0;
  logic [15:0] sample_o;
  logic        sample_valid_o;

  int n_chk = 0, n_err = 0;
  int mm = 0;
  int qerr [4];
  int last_a = 0, last_e = 0;
  bit cmp_en = 1'b0;

  // {tuning word, expected period in cycles}
  localparam logic [31:0] VEC [5] = '{
    {16'd256,   16'd256},
    {16'd512,   16'd128},
    {16'd1024,  16'd64},
    {16'd4096,  16'd16},
    {16'd16384, 16'd4}
  };

  always #10 clk_i = ~clk_i;

  dds_quarter_sine dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tune_i         (tune_i),
    .tune_load_i    (tune_load_i),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o)
  );

  // independent reference: phase history and validity
  logic [15:0] m_phase, m_tune, h1, h2;
  logic        mv1, mv2;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase <= '0; m_tune <= '0; h1 <= '0; h2 <= '0; mv1 <= 1'b0; mv2 <= 1'b0;
    end else begin
      m_phase <= m_phase + m_tune;
      if (tune_load_i) m_tune <= tune_i;
      h1 <= m_phase; h2 <= h1; mv1 <= 1'b1; mv2 <= mv1;
    end
  end

  function automatic int exp_sample(input logic [15:0] p);
    int  i;
    real s;
    int  m;
    i = int'(p[13:6]);
    if (p[14]) i = 255 - i;
    s = $sin((2.0 * i + 1.0) * 3.14159265358979 / 1024.0);
    m = $rtoi(s * 32767.0 + 0.5);
    return p[15] ? -m : m;
  endfunction

  int mon_a, mon_e;
  always @(negedge clk_i) begin
    if (cmp_en && rst_ni) begin
      if (sample_valid_o !== mv2) mm++;
      else if (mv2) begin
        mon_e = exp_sample(h2);
        mon_a = int'($signed(sample_o));
        if (mon_a - mon_e > 1 || mon_e - mon_a > 1) begin
          mm++; qerr[h2[15:14]]++; last_a = mon_a; last_e = mon_e;
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    mm = 0;
    for (int q = 0; q < 4; q++) qerr[q] = 0;
  endtask

  task automatic load_tune(input logic [15:0] t);
    @(negedge clk_i);
    tune_i = t; tune_load_i = 1'b1;
    @(negedge clk_i);
    tune_load_i = 1'b0;
  endtask

  task automatic measure_period(output int n);
    logic prev;
    int   cnt;
    prev = sample_o[15];
    cnt  = 0;
    while (!(prev && !sample_o[15]) && cnt < 70000) begin
      prev = sample_o[15]; @(negedge clk_i); cnt++;
    end
    n = 0;
    prev = sample_o[15];
    do begin
      @(negedge clk_i); n++;
      if (prev && !sample_o[15]) break;
      prev = sample_o[15];
    end while (n < 70000);
  endtask

  int s0, per, chg;
  logic [15:0] prev_s;

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    tick(3);
    check(sample_o == 0 && !sample_valid_o, "R10 reset state", int'(sample_o), 0);
    rst_ni = 1'b1;
    tick(1);
    check(!sample_valid_o, "R9 valid low after one edge", int'(sample_valid_o), 0);
    tick(1);
    check(sample_valid_o, "R9 valid on second edge", int'(sample_valid_o), 1);
    s0 = int'($signed(sample_o));
    check(s0 - exp_sample(16'h0) <= 1 && exp_sample(16'h0) - s0 <= 1, "R5 first sample", s0, exp_sample(16'h0));
    cmp_en = 1'b1;

    // tuning word 0 after reset: output frozen
    clr();
    tick(20);
    check(int'($signed(sample_o)) == s0 && mm == 0, "R2 zero word freezes", int'($signed(sample_o)), s0);

    // vector table: period and samples per tuning word
    for (int v = 0; v < 5; v++) begin
      clr();
      load_tune(VEC[v][31:16]);
      tick(2 * int'(VEC[v][15:0]) + 8);
      measure_period(per);
      check(per == int'(VEC[v][15:0]), "R3 period", per, int'(VEC[v][15:0]));
      check(mm == 0, "R8 magnitude", last_a, last_e);
    end

    // one index per cycle, full period, errors split by quadrant
    load_tune(16'd64);
    tick(8);
    clr();
    tick(1024);
    check(qerr[0] == 0, "R5 quadrant 0", last_a, last_e);
    check(qerr[1] == 0, "R6 quadrant 1 mirror", last_a, last_e);
    check(qerr[2] + qerr[3] == 0, "R7 negated half", last_a, last_e);

    // low phase bits do not move the table address
    load_tune(16'd1);
    tick(4);
    clr();
    chg = 0;
    prev_s = sample_o;
    for (int c = 0; c < 256; c++) begin
      tick(1);
      if (sample_o != prev_s) chg++;
      prev_s = sample_o;
    end
    check(chg <= 4 && chg >= 3 && mm == 0, "R4 low bits", chg, 4);

    // word ignored without strobe; phase kept across loads
    clr();
    load_tune(16'd300);
    tick(50);
    tune_i = 16'd5000;
    tick(100);
    check(mm == 0, "R1 no strobe ignored", last_a, last_e);
    clr();
    load_tune(16'd777);
    tick(100);
    check(mm == 0, "R1 phase continuous load", last_a, last_e);

    // wrap-down word
    clr();
    load_tune(16'hFFFF);
    tick(300);
    check(mm == 0, "R2 modulo wrap", last_a, last_e);

    // reset while running
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick(1);
    check(sample_o == 0 && !sample_valid_o, "R10 mid-run reset", int'(sample_o), 0);
    rst_ni = 1'b1;
    tick(3);
    s0 = int'($signed(sample_o));
    tick(10);
    check(int'($signed(sample_o)) == s0 && s0 - exp_sample(16'h0) <= 1 && exp_sample(16'h0) - s0 <= 1,
          "R10 word cleared", int'($signed(sample_o)), exp_sample(16'h0));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule